// File: doc/BRIEF.md
# Accumulator Data Path with Conditioned Operand Register

This block is the arithmetic data path of a small accumulator machine. It holds an accumulator register fed by a single ripple-carry adder. A second register, the operand register, prepares the adder's second input. The adder has no subtract or decrement logic of its own. Every arithmetic result comes from steering the two adder inputs and the carry-in, and from putting the operand register in the right state beforehand.

The operand register has four modes. It can hold its value, invert itself, fill with ones, or capture the memory data bus. A controller outside the block combines these modes with the adder input selects to form its operations:

- **Clear:** zero on both adder inputs and carry 0.
- **Increment:** accumulator plus zero with carry 1.
- **Decrement:** accumulator plus an all-ones operand.
- **Add:** accumulator plus the captured operand.
- **Subtract:** accumulator plus the inverted operand with carry 1.
- **Load:** zero plus the operand.

The adder is built as a chain of 4-bit full-adder groups, and the carry is passed from one group to the next. The accumulator value and its sign bit are the outputs. A hold input keeps the accumulator unchanged. When the `ALWAYS_LOAD` parameter is set, the hold input is ignored and the sum is stored on every clock.

Top module: `acc_datapath`

## Requirements
- R1: While `rst_n` is low and after it rises, the accumulator and the operand register both read 0 and `acc_neg` is 0.
- R2: `b_mode` = 2'b11 (load) stores `mem_data` into the operand register at the clock edge.
- R3: `b_mode` = 2'b01 (complement) replaces the operand register with its bitwise inverse at the clock edge.
- R4: `b_mode` = 2'b10 (ones) sets every operand register bit to 1 at the clock edge.
- R5: `b_mode` = 2'b00 (hold) keeps the operand register unchanged, whatever `mem_data` is.
- R6: With `acc_hold` = 0, the accumulator takes the sum of three terms, modulo 2^W, at the clock edge. The terms are: the A term, which is the accumulator when `a_zero` = 0 and 0 when it is 1; the B term, which is the operand register when `b_pass` = 1 and 0 when it is 0; and `cin`. The operand register value used is the one present before that edge.
- R7: With `acc_hold` = 1 and `ALWAYS_LOAD` = 0, the accumulator keeps its value.
- R8: `acc_neg` equals bit W-1 of the accumulator.
- R9: `a_zero` = 1, `b_pass` = 0 and `cin` = 0 together clear the accumulator to 0.
- R10: Carries pass between the 4-bit groups. For example, 8'h0F plus 1 gives 8'h10, and 8'hFF plus 1 gives 8'h00.
- R11: Subtract (load the operand, then complement it, then add with `cin` = 1) yields acc − operand modulo 2^W. Decrement (ones, then add with `cin` = 0) yields acc − 1 modulo 2^W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_zero | input | 1 | 1 drives zero onto the adder A input; 0 selects the accumulator |
| b_pass | input | 1 | 1 passes the operand register to the adder B input; 0 drives zero |
| cin | input | 1 | Adder carry-in |
| b_mode | input | 2 | Operand register mode: 00 hold, 01 complement, 10 ones, 11 load |
| acc_hold | input | 1 | 1 keeps the accumulator (ignored when ALWAYS_LOAD = 1) |
| mem_data | input | W | Memory data bus, captured in load mode |
| acc_q | output | W | Accumulator value |
| acc_neg | output | 1 | Sign bit of the accumulator |

## Verification
The operand register and the accumulator each change one clock edge after their controls are applied. The operand value seen by the adder is the one registered before the current edge. For that reason, a subtract takes three edges: load, complement, then add. Decrement takes two edges: ones, then add. Load or add takes two edges: capture, then sum. The bench drives every control on the falling edge and reads outputs on the next falling edge, which is half a period after the edge that updates them. Operand-register modes are checked at the ports by a following zero-plus-operand step. The add and subtract sweeps cover a grid of accumulator and operand values spread across the full 8-bit range.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;

    // Operand register modes; encoding is part of the port contract.
    typedef enum logic [1:0] {
        OPR_HOLD  = 2'b00,
        OPR_INV   = 2'b01,
        OPR_ONES  = 2'b10,
        OPR_LOAD  = 2'b11
    } opr_mode_e;

    localparam int unsigned GROUP_W = 4;

endpackage

// File: rtl/acc_nibble_add.sv
module acc_nibble_add #(
    parameter int unsigned GW = 4
) (
    input  logic [GW-1:0] a,
    input  logic [GW-1:0] b,
    input  logic          ci,
    output logic [GW-1:0] s,
    output logic          co
);
    logic [GW:0] c;

    assign c[0] = ci;

    // Explicit ripple of full adders, one per bit.
    for (genvar i = 0; i < GW; i++) begin : g_fa
        assign s[i]   = a[i] ^ b[i] ^ c[i];
        assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
    end

    assign co = c[GW];
endmodule

// File: rtl/acc_operand_reg.sv
module acc_operand_reg
    import acc_dp_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  opr_mode_e    mode,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    logic [W-1:0] q_nxt;

    always_comb begin
        unique case (mode)
            OPR_HOLD: q_nxt = q;
            OPR_INV:  q_nxt = ~q;
            OPR_ONES: q_nxt = '1;
            OPR_LOAD: q_nxt = din;
            default:  q_nxt = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_nxt;
    end
endmodule

// File: rtl/acc_register.sv
module acc_register #(
    parameter int unsigned W           = 8,
    parameter bit          ALWAYS_LOAD = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic take;

    if (ALWAYS_LOAD) begin : g_every
        logic hold_unused;
        assign hold_unused = hold;
        assign take        = 1'b1;
    end else begin : g_gated
        assign take = ~hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (take) q <= d;
    end
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
    import acc_dp_pkg::*;
#(
    parameter int unsigned W           = 8,
    parameter bit          ALWAYS_LOAD = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         a_zero,
    input  logic         b_pass,
    input  logic         cin,
    input  logic [1:0]   b_mode,
    input  logic         acc_hold,
    input  logic [W-1:0] mem_data,
    output logic [W-1:0] acc_q,
    output logic         acc_neg
);
    localparam int unsigned NGRP = W / GROUP_W;

    logic [W-1:0]  breg_q;
    logic [W-1:0]  add_a;
    logic [W-1:0]  add_b;
    logic [W-1:0]  sum;
    logic [NGRP:0] carry;
    logic          carry_out_unused;

    acc_operand_reg #(.W(W)) u_opr (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (opr_mode_e'(b_mode)),
        .din   (mem_data),
        .q     (breg_q)
    );

    // Input steering: the only way operations are formed.
    assign add_a = a_zero ? '0 : acc_q;
    assign add_b = b_pass ? breg_q : '0;

    assign carry[0] = cin;
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        acc_nibble_add #(.GW(GROUP_W)) u_add (
            .a  (add_a[g*GROUP_W +: GROUP_W]),
            .b  (add_b[g*GROUP_W +: GROUP_W]),
            .ci (carry[g]),
            .s  (sum[g*GROUP_W +: GROUP_W]),
            .co (carry[g+1])
        );
    end
    assign carry_out_unused = carry[NGRP];

    acc_register #(.W(W), .ALWAYS_LOAD(ALWAYS_LOAD)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (acc_hold),
        .d     (sum),
        .q     (acc_q)
    );

    assign acc_neg = acc_q[W-1];
endmodule

// File: rtl/acc_datapath_chk.sv
module acc_datapath_chk #(
    parameter int unsigned W           = 8,
    parameter bit          ALWAYS_LOAD = 1'b0
) (
    input logic         clk,
    input logic         rst_n,
    input logic         a_zero,
    input logic         b_pass,
    input logic         cin,
    input logic [1:0]   b_mode,
    input logic         acc_hold,
    input logic [W-1:0] mem_data,
    input logic [W-1:0] acc_q,
    input logic [W-1:0] breg_q
);
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (acc_q == '0 && breg_q == '0));

    a_r2_opr_load: assert property (@(posedge clk) disable iff (!rst_n)
        b_mode == 2'b11 |=> breg_q == $past(mem_data));

    a_r3_opr_invert: assert property (@(posedge clk) disable iff (!rst_n)
        b_mode == 2'b01 |=> breg_q == ~$past(breg_q));

    a_r4_opr_ones: assert property (@(posedge clk) disable iff (!rst_n)
        b_mode == 2'b10 |=> &breg_q);

    a_r5_opr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        b_mode == 2'b00 |=> $stable(breg_q));

    a_r6_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_hold || ALWAYS_LOAD) |=>
            acc_q == W'(($past(a_zero) ? {W{1'b0}} : $past(acc_q))
                      + ($past(b_pass) ? $past(breg_q) : {W{1'b0}})
                      + W'($past(cin))));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_hold && !ALWAYS_LOAD) |=> $stable(acc_q));

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (a_zero && !b_pass && !cin && (!acc_hold || ALWAYS_LOAD)) |=> acc_q == '0);
endmodule

bind acc_datapath acc_datapath_chk #(.W(W), .ALWAYS_LOAD(ALWAYS_LOAD)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_zero   (a_zero),
    .b_pass   (b_pass),
    .cin      (cin),
    .b_mode   (b_mode),
    .acc_hold (acc_hold),
    .mem_data (mem_data),
    .acc_q    (acc_q),
    .breg_q   (breg_q)
);

// File: tb/tb_acc_datapath.sv
module tb_acc_datapath;
    localparam logic [1:0] M_HOLD = 2'b00, M_INV = 2'b01, M_ONES = 2'b10, M_LOAD = 2'b11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a_zero = 1'b0, b_pass = 1'b0, cin = 1'b0, acc_hold = 1'b1;
    logic [1:0] b_mode = M_HOLD;
    logic [7:0] mem_data = 8'h00;
    logic [7:0] acc_q;
    logic       acc_neg;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    acc_datapath dut (
        .clk(clk), .rst_n(rst_n), .a_zero(a_zero), .b_pass(b_pass), .cin(cin),
        .b_mode(b_mode), .acc_hold(acc_hold), .mem_data(mem_data),
        .acc_q(acc_q), .acc_neg(acc_neg)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive on falling edge, let the rising edge act, return on next falling edge.
    task automatic cyc(input logic az, input logic bp, input logic ci,
                       input logic [1:0] bm, input logic hd, input logic [7:0] md);
        a_zero = az; b_pass = bp; cin = ci; b_mode = bm; acc_hold = hd; mem_data = md;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic put_acc(input logic [7:0] x);
        cyc(1, 0, 0, M_LOAD, 1, x);
        cyc(1, 1, 0, M_HOLD, 0, 8'h00);
    endtask

    initial begin
        @(negedge clk);
        chk("R1 acc in reset", acc_q, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1, 1, 0, M_HOLD, 0, 8'h00);
        chk("R1 operand zero after reset", acc_q, 8'h00);
        chk("R1 sign after reset", {7'd0, acc_neg}, 8'h00);

        // R2 load mode then zero+operand
        put_acc(8'hA7);
        chk("R2 load path", acc_q, 8'hA7);
        chk("R8 sign set", {7'd0, acc_neg}, 8'h01);

        // R5: operand held across changing bus
        cyc(1, 0, 0, M_LOAD, 1, 8'h5A);
        cyc(1, 0, 0, M_HOLD, 1, 8'hFF);
        cyc(1, 0, 0, M_HOLD, 1, 8'h13);
        chk("R7 acc held", acc_q, 8'hA7);
        cyc(1, 1, 0, M_HOLD, 0, 8'hC3);
        chk("R5 operand held", acc_q, 8'h5A);
        chk("R8 sign clear", {7'd0, acc_neg}, 8'h00);

        // R3 complement
        cyc(1, 0, 0, M_INV, 1, 8'h00);
        cyc(1, 1, 0, M_HOLD, 0, 8'h00);
        chk("R3 invert", acc_q, 8'hA5);

        // R4 ones
        cyc(1, 0, 0, M_ONES, 1, 8'h00);
        cyc(1, 1, 0, M_HOLD, 0, 8'h00);
        chk("R4 ones", acc_q, 8'hFF);

        // R9 clear
        cyc(1, 0, 0, M_HOLD, 0, 8'h77);
        chk("R9 clear", acc_q, 8'h00);

        // R11 decrement through zero
        cyc(1, 0, 0, M_ONES, 1, 8'h00);
        cyc(0, 1, 0, M_HOLD, 0, 8'h00);
        chk("R11 decrement 0", acc_q, 8'hFF);

        // R10 carry across groups
        put_acc(8'h0F);
        cyc(0, 0, 1, M_HOLD, 0, 8'h00);
        chk("R10 0F+1", acc_q, 8'h10);
        put_acc(8'hFF);
        cyc(0, 0, 1, M_HOLD, 0, 8'h00);
        chk("R10 FF+1", acc_q, 8'h00);

        // R7 hold with active-looking controls
        put_acc(8'h3C);
        cyc(0, 1, 1, M_HOLD, 1, 8'h00);
        chk("R7 hold under op", acc_q, 8'h3C);

        // R6/R11 sweep of add and subtract
        for (int x = 0; x < 256; x += 15) begin
            for (int y = 0; y < 256; y += 13) begin
                put_acc(8'(x));
                cyc(1, 0, 0, M_LOAD, 1, 8'(y));
                cyc(0, 1, 0, M_HOLD, 0, 8'h00);
                chk("R6 add", acc_q, 8'(x + y));
                put_acc(8'(x));
                cyc(1, 0, 0, M_LOAD, 1, 8'(y));
                cyc(1, 0, 0, M_INV, 1, 8'h00);
                cyc(0, 1, 1, M_HOLD, 0, 8'h00);
                chk("R11 subtract", acc_q, 8'(x - y));
                chk("R8 sign after subtract", {7'd0, acc_neg}, {7'd0, 8'(x - y) >= 8'h80});
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule